// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation converter. The analog side sits outside it: the capacitor array, the input switches and the charge pump. It closes the input switch for a fixed acquisition window and then drives a trial code to the analog side. A single comparator bit comes back, and the block searches the code one bit per clock, starting at the top bit. Each finished code is stored in one of four result registers.

A control write sets three things. The first is the channel, or the group of four channels. The second is whether all four conversions use that one channel or step through the group. The third is whether the four-conversion sequence runs once or repeats. A completion flag rises when the fourth register is written. A power enable starts a settling counter, and conversion requests wait until that counter has expired.

Top module: `sar_seq`

## Requirements
- R1: After reset, all four result registers read zero, and `done`, `ready`, `busy`, `sample_sw`, `conv_valid` and `trial_code` are all low or zero.
- R2: `ready` goes high exactly SETTLE_CYC clock edges after `pwr_en` is first sampled high. While `ready` is low, no conversion runs (`busy` stays low). A control write made before that point is held and starts once `ready` is high.
- R3: Each conversion opens with an acquisition window. In it, `sample_sw` is high for exactly SAMPLE_CYC (12) consecutive cycles and `trial_code` is zero.
- R4: After the window come exactly eight search cycles, top bit first. In each one, `trial_code` is the code decided so far with the current bit set. That bit is kept only if `cmp_below` is low (input not below the trial). The first trial is therefore 8'h80, and the stored result equals the input code.
- R5: With `ctl_multi` = 0, all four conversions use channel `ctl_chan`. They fill result slots 0, 1, 2, 3 in that order. Slot k is `res_flat[8k+7:8k]`.
- R6: With `ctl_multi` = 1, the group is given by `ctl_chan[2]`. Conversion k uses channel {`ctl_chan[2]`, k[1:0]} and writes slot k.
- R7: `done` rises only in the cycle when slot 3 is written. In one-shot mode (`ctl_cont` = 0), the block then returns to idle and `busy` goes low.
- R8: In continuous mode (`ctl_cont` = 1), the block goes straight back to slot 0 after slot 3. `done` stays high while the later rounds overwrite the registers.
- R9: A control write aborts any sequence in progress, clears `done` in the next cycle, and restarts at slot 0 using the new settings.
- R10: `conv_valid` pulses for one cycle each time a result register is written. Outside those pulses the result registers do not change.
- R11: Dropping `pwr_en` aborts the conversion in progress. In the next cycle `busy` and `ready` are low, and no result register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Converter power enable; starts the settling count |
| ctl_wr | input | 1 | Control write strobe |
| ctl_chan | input | 3 | Channel (single mode) or group in bit 2 (multi mode) |
| ctl_multi | input | 1 | 1: step through four channels of the group |
| ctl_cont | input | 1 | 1: repeat the four-conversion sequence |
| cmp_below | input | 1 | Comparator: analog input below the trial level |
| trial_code | output | 8 | Trial code to the capacitor array, zero outside search |
| sample_sw | output | 1 | Input switch closed (acquisition window) |
| chan_sel | output | 3 | Channel currently routed to the converter |
| res_flat | output | 32 | Four result registers, slot k in bits 8k+7:8k |
| conv_valid | output | 1 | One-cycle pulse when a result register is written |
| done | output | 1 | Conversion-complete flag |
| ready | output | 1 | Settling delay has expired |
| busy | output | 1 | A sequence is active |

## Verification
Several rules are checked by the assertions on every cycle. The acquisition window never exceeds 12 cycles, and it always reaches 12 unless it is aborted. The trial code stays zero while the switch is closed. Nothing runs before `ready`. `done` only rises together with a result write. A control write always clears `done`, and the result registers hold steady between write pulses. Other behaviour can only be shown by the bench's scenarios, because it needs a model of the analog input: that every stored code equals that input, that single and multi mode pick the right channels and slot order, that the flag waits for the fourth slot and persists across continuous rounds, and that aborts by a new write or by losing power leave the registers alone.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_settle.sv
module sar_settle #(
    parameter int SETTLE_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    output logic ready
);
    localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!pwr_en)
            cnt_d = '0;
        else if (cnt_q == LIM)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == LIM);
endmodule

// File: rtl/sar_step.sv
module sar_step #(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] sar,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              cmp_below,
    output logic [DATA_W-1:0] trial,
    output logic [DATA_W-1:0] sar_next
);
    logic [DATA_W-1:0] mask;

    always_comb begin
        mask     = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
        trial    = sar | mask;
        sar_next = cmp_below ? sar : (sar | mask);
    end
endmodule

// File: rtl/sar_bank.sv
module sar_bank #(
    parameter int DATA_W  = 8,
    parameter int NUM_RES = 4,
    localparam int SLOT_W = $clog2(NUM_RES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SLOT_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_RES*DATA_W-1:0] res_flat
);
    for (genvar g = 0; g < NUM_RES; g++) begin : g_slot
        logic [DATA_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_idx == SLOT_W'(g)))
                val_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign res_flat[g*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_RES    = 4,
    parameter int CH_W       = 3,
    parameter int SAMPLE_CYC = 12,
    parameter int SETTLE_CYC = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pwr_en,
    input  logic                      ctl_wr,
    input  logic [CH_W-1:0]           ctl_chan,
    input  logic                      ctl_multi,
    input  logic                      ctl_cont,
    input  logic                      cmp_below,
    output logic [DATA_W-1:0]         trial_code,
    output logic                      sample_sw,
    output logic [CH_W-1:0]           chan_sel,
    output logic [NUM_RES*DATA_W-1:0] res_flat,
    output logic                      conv_valid,
    output logic                      done,
    output logic                      ready,
    output logic                      busy
);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int SLOT_W = $clog2(NUM_RES);
    localparam int SCNT_W = (SAMPLE_CYC < 2) ? 1 : $clog2(SAMPLE_CYC);
    localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(SAMPLE_CYC - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_RES - 1);
    localparam logic [BIT_W-1:0]  BIT_TOP   = BIT_W'(DATA_W - 1);

    typedef struct packed {
        sar_state_e        st;
        logic [SCNT_W-1:0] scnt;
        logic [BIT_W-1:0]  bit_idx;
        logic [DATA_W-1:0] sar;
        logic [SLOT_W-1:0] slot;
        logic [CH_W-1:0]   chan;
        logic              multi;
        logic              cont;
        logic              done;
        logic              pend;
        logic              cvalid;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              settle_rdy;
    logic [DATA_W-1:0] step_trial;
    logic [DATA_W-1:0] step_next;
    logic              bank_we;

    sar_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_en (pwr_en),
        .ready  (settle_rdy)
    );

    sar_step #(.DATA_W(DATA_W)) u_step (
        .sar       (seq_q.sar),
        .bit_idx   (seq_q.bit_idx),
        .cmp_below (cmp_below),
        .trial     (step_trial),
        .sar_next  (step_next)
    );

    sar_bank #(.DATA_W(DATA_W), .NUM_RES(NUM_RES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bank_we),
        .wr_idx   (seq_q.slot),
        .wr_data  (step_next),
        .res_flat (res_flat)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.cvalid = 1'b0;
        bank_we      = 1'b0;

        if (!pwr_en)
            seq_d.st = ST_IDLE;

        if (ctl_wr) begin
            seq_d.chan  = ctl_chan;
            seq_d.multi = ctl_multi;
            seq_d.cont  = ctl_cont;
            seq_d.done  = 1'b0;
            seq_d.pend  = 1'b1;
            seq_d.slot  = '0;
            seq_d.st    = ST_IDLE;
        end else if (pwr_en) begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (seq_q.pend && settle_rdy) begin
                        seq_d.st   = ST_SAMPLE;
                        seq_d.scnt = '0;
                        seq_d.pend = 1'b0;
                    end
                end
                ST_SAMPLE: begin
                    if (seq_q.scnt == SCNT_LAST) begin
                        seq_d.st      = ST_CONV;
                        seq_d.bit_idx = BIT_TOP;
                        seq_d.sar     = '0;
                    end else begin
                        seq_d.scnt = seq_q.scnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    seq_d.sar = step_next;
                    if (seq_q.bit_idx == '0) begin
                        bank_we      = 1'b1;
                        seq_d.cvalid = 1'b1;
                        seq_d.scnt   = '0;
                        if (seq_q.slot == SLOT_LAST) begin
                            seq_d.slot = '0;
                            seq_d.done = 1'b1;
                            seq_d.st   = seq_q.cont ? ST_SAMPLE : ST_IDLE;
                        end else begin
                            seq_d.slot = seq_q.slot + 1'b1;
                            seq_d.st   = ST_SAMPLE;
                        end
                    end else begin
                        seq_d.bit_idx = seq_q.bit_idx - 1'b1;
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        chan_sel = seq_q.chan;
        if (seq_q.multi)
            chan_sel = {seq_q.chan[CH_W-1:SLOT_W], seq_q.slot};
    end

    assign trial_code = (seq_q.st == ST_CONV) ? step_trial : '0;
    assign sample_sw  = (seq_q.st == ST_SAMPLE);
    assign conv_valid = seq_q.cvalid;
    assign done       = seq_q.done;
    assign ready      = settle_rdy;
    assign busy       = (seq_q.st != ST_IDLE);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int DATA_W     = 8,
    parameter int NUM_RES    = 4,
    parameter int SAMPLE_CYC = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      pwr_en,
    input logic                      ctl_wr,
    input logic                      sample_sw,
    input logic [DATA_W-1:0]         trial_code,
    input logic [NUM_RES*DATA_W-1:0] res_flat,
    input logic                      conv_valid,
    input logic                      done,
    input logic                      ready,
    input logic                      busy
);
    localparam int RW = $clog2(SAMPLE_CYC + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_q <= '0;
        else if (!sample_sw) run_q <= '0;
        else if (run_q != '1) run_q <= run_q + 1'b1;
    end

    // R3: the window never outlasts its length
    assert_window_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_sw |-> (run_q < RW'(SAMPLE_CYC)));

    // R3: an unaborted window lasts its full length
    assert_window_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_sw) && !$past(ctl_wr) && $past(pwr_en)) |-> (run_q == RW'(SAMPLE_CYC)));

    // R3: no trial code while the input switch is closed
    assert_quiet_trial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_sw |-> (trial_code == '0));

    // R2: nothing runs before settling completes
    assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !busy);

    // R7: the flag only rises together with a result write
    assert_done_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> conv_valid);

    // R9: a control write clears the flag
    assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr) |-> (!done && !conv_valid));

    // R10: results only move with a write pulse
    assert_res_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid |-> $stable(res_flat));

    // R11: loss of power stops the sequence at once
    assert_power_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |=> (!busy && !conv_valid));
endmodule

bind sar_seq sar_seq_chk #(
    .DATA_W     (DATA_W),
    .NUM_RES    (NUM_RES),
    .SAMPLE_CYC (SAMPLE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en     (pwr_en),
    .ctl_wr     (ctl_wr),
    .sample_sw  (sample_sw),
    .trial_code (trial_code),
    .res_flat   (res_flat),
    .conv_valid (conv_valid),
    .done       (done),
    .ready      (ready),
    .busy       (busy)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
    localparam int SETTLE = 40;
    localparam int SAMP   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_en = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_chan = '0;
    logic        ctl_multi = 1'b0;
    logic        ctl_cont = 1'b0;
    logic        cmp_below;
    logic [7:0]  trial_code;
    logic        sample_sw;
    logic [2:0]  chan_sel;
    logic [31:0] res_flat;
    logic        conv_valid;
    logic        done;
    logic        ready;
    logic        busy;

    int total = 0;
    int bad   = 0;

    logic [7:0] ain [8];
    logic [7:0] model [4];

    typedef struct {
        int         slot;
        logic [7:0] val;
        logic       dn;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    assign cmp_below = (ain[chan_sel] < trial_code);

    sar_seq #(.SETTLE_CYC(SETTLE), .SAMPLE_CYC(SAMP)) u_sar_seq (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .ctl_wr(ctl_wr),
        .ctl_chan(ctl_chan), .ctl_multi(ctl_multi), .ctl_cont(ctl_cont),
        .cmp_below(cmp_below), .trial_code(trial_code), .sample_sw(sample_sw),
        .chan_sel(chan_sel), .res_flat(res_flat), .conv_valid(conv_valid),
        .done(done), .ready(ready), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: queue the expected results, then write the control register
    task automatic start_seq(input logic [2:0] ch, input logic multi, input logic cont,
                             input int rounds);
        for (int r = 0; r < rounds; r++) begin
            for (int s = 0; s < 4; s++) begin
                logic [2:0] c;
                exp_t e;
                c = multi ? {ch[2], 2'(s)} : ch;
                e.slot = s;
                e.val  = ain[c];
                e.dn   = cont ? ((r > 0) || (s == 3)) : (s == 3);
                exp_q.push_back(e);
            end
        end
        @(negedge clk);
        ctl_chan = ch; ctl_multi = multi; ctl_cont = cont; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_drain(input bit need_idle);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && (!need_idle || !busy)) break;
        end
    endtask

    // monitor: each write pulse pops one expected item (R5, R6, R7, R8, R10)
    always @(negedge clk) begin
        if (rst_n && conv_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected write", 1, 0);
            end else begin
                exp_t e;
                bit ok;
                e = exp_q.pop_front();
                model[e.slot] = e.val;
                ok = (done == e.dn);
                for (int i = 0; i < 4; i++)
                    if (res_flat[i*8 +: 8] != model[i]) ok = 1'b0;
                chk(ok, $sformatf("R5/R6/R7/R8 slot%0d", e.slot),
                    {res_flat, 3'b0, done}, {model[3], model[2], model[1], model[0], 3'b0, e.dn});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] snap;
        ain[0] = 8'hA5; ain[1] = 8'h00; ain[2] = 8'hFF; ain[3] = 8'h01;
        ain[4] = 8'h80; ain[5] = 8'h7F; ain[6] = 8'h3C; ain[7] = 8'hC3;
        for (int i = 0; i < 4; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(res_flat == '0 && !done && !ready && !busy && !sample_sw && !conv_valid
            && trial_code == '0, "R1 reset", {res_flat[7:0], done, ready, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: request made while unpowered is held
        start_seq(3'd2, 1'b0, 1'b0, 1);
        repeat (5) @(negedge clk);
        chk(!busy && !ready, "R2 held while unpowered", {busy, ready}, 0);

        pwr_en = 1'b1;
        n = 0;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            if (ready) begin n = k; break; end
        end
        chk(n == SETTLE, "R2 settle edges", n, SETTLE);

        // R3: acquisition window
        for (int k = 0; k < 10 && !sample_sw; k++) @(negedge clk);
        chk(sample_sw == 1'b1, "R2 start after ready", sample_sw, 1);
        n = 0;
        while (sample_sw && n < 50) begin
            if (trial_code != '0) chk(1'b0, "R3 trial during sample", trial_code, 0);
            n++;
            @(negedge clk);
        end
        chk(n == SAMP, "R3 window length", n, SAMP);

        // R4: search order
        chk(trial_code == 8'h80, "R4 first trial", trial_code, 8'h80);
        @(negedge clk);
        chk(trial_code == 8'hC0, "R4 second trial", trial_code, 8'hC0);
        n = 2;
        @(negedge clk);
        while (trial_code != '0 && !sample_sw && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(n == 8, "R4 eight steps", n, 8);

        wait_drain(1'b1);
        chk(done && !busy, "R7 one-shot ends", {done, busy}, 2'b10);

        // R6: multi-channel, upper group
        start_seq(3'd4, 1'b1, 1'b0, 1);
        wait_drain(1'b1);
        chk(exp_q.size() == 0 && done, "R6 group complete", exp_q.size(), 0);

        // R5 and R8: single channel continuous, two rounds
        start_seq(3'd0, 1'b0, 1'b1, 2);
        wait_drain(1'b0);
        chk(done && busy, "R8 still running with flag", {done, busy}, 2'b11);

        // R9: abort during third round's acquisition
        for (int k = 0; k < 100 && !sample_sw; k++) @(negedge clk);
        start_seq(3'd1, 1'b1, 1'b0, 1);
        chk(!done, "R9 flag cleared", done, 0);
        wait_drain(1'b1);
        chk(done && !busy, "R9 new sequence done", {done, busy}, 2'b10);

        // R11: power loss mid-search
        start_seq(3'd7, 1'b0, 1'b0, 1);
        for (int k = 0; k < 200 && trial_code == '0; k++) @(negedge clk);
        snap = res_flat;
        exp_q.delete();
        pwr_en = 1'b0;
        @(negedge clk);
        chk(!busy && !ready, "R11 abort", {busy, ready}, 0);
        repeat (30) @(negedge clk);
        chk(res_flat == snap, "R11 results kept", res_flat, snap);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule